// File: doc/BRIEF.md
# Multi-Target Interrupt Fan-Out Dispatcher

This block takes one interrupt delivery request and turns it into a series of per-agent commands for up to 255 attached interrupt agents. A request carries a 256-bit destination mask, a delivery mode, an 8-bit vector, a trigger bit and a level bit. The mask is organised as eight 32-bit words, and bit `i` of word `w` names agent `w*32+i`. A presence vector marks which agent slots are populated. Slot 255 never holds an agent.

The dispatcher walks the mask one word per cycle. An empty word costs one cycle. Inside a word that has bits set, it issues one agent per cycle, lowest index first. Each issued agent receives a one-cycle strobe on exactly one of four command outputs: set-interrupt (with vector and trigger), INIT, startup (with vector), or arbitration-ID reload. The target index and payload appear on shared command buses. Lowest-priority mode picks only the first set bit of the raw mask. When the walk ends, a single-cycle `done` pulse follows the last command.

The controller has three states. `ST_IDLE` moves to `ST_SCAN` when a request arrives. `ST_SCAN` stays put while words or bits remain. It moves to `ST_FINISH` after the last word, or after the first hit in lowest-priority mode. `ST_FINISH` pulses `done` and returns to `ST_IDLE`.

Top module: `irq_fanout_dispatch`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and all four command strobes are 0.
- R2: Mask bit `i` of word `w` (flat bit `w*32+i`) addresses agent `w*32+i`, and `cmd_agent` carries that index with each strobe.
- R3: Fixed mode (`req_mode`=0) gives every selected, present agent one `cmd_set` strobe carrying the request vector and trigger bit, in ascending agent order.
- R4: Lowest-priority mode (`req_mode`=1) considers only the lowest set bit of the raw mask, searching from word 0. That agent alone gets `cmd_set`, and only if it is present. An all-zero mask, or an absent first target, delivers nothing.
- R5: INIT mode (`req_mode`=2) with `req_level`=1 or `req_trig`=0 gives each selected, present agent a `cmd_init` strobe and never a `cmd_set`.
- R6: INIT mode with `req_level`=0 and `req_trig`=1 sends no INIT. It gives each selected, present agent a `cmd_arb` strobe instead (reload arbitration ID from own ID).
- R7: Startup mode (`req_mode`=3) gives each selected, present agent a `cmd_start` strobe carrying the vector.
- R8: A selected bit whose slot is not present (including bit 255) produces no command and costs no cycle in modes other than lowest-priority.
- R9: At most one strobe is active per cycle. Each zero word takes one scan cycle and each issued agent takes one, so the scan lasts `8 - nonzero_words + issued` cycles (`first_hit_word + 1`, or 8 with no hit, in lowest-priority mode). `done` goes high for exactly one cycle, one cycle after the last strobe. The acceptance edge to `done` spans scan cycles + 2 edges.
- R10: `req_valid` is ignored while `busy` is 1. A request raised during a walk neither alters the commands issued nor causes a second `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_mask | input | 256 | Destination mask, eight 32-bit words |
| req_mode | input | 2 | 0 fixed, 1 lowest-priority, 2 INIT, 3 startup |
| req_vector | input | 8 | Interrupt or startup vector |
| req_trig | input | 1 | Trigger bit, 1 = level |
| req_level | input | 1 | Level bit, 1 = asserted |
| agent_present | input | 255 | Presence bit per agent slot |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse after the final command |
| cmd_set | output | 1 | Set-interrupt strobe |
| cmd_init | output | 1 | INIT strobe |
| cmd_start | output | 1 | Startup strobe |
| cmd_arb | output | 1 | Arbitration-ID reload strobe |
| cmd_agent | output | 8 | Target agent index |
| cmd_vector | output | 8 | Vector for set-interrupt or startup |
| cmd_trig | output | 1 | Trigger bit for set-interrupt |

## Verification
The bench covers several mask shapes:
- Sparse bits spread over several words, which tells word order apart from bit order.
- An all-zero mask, which exposes a walk that stops early.
- A completely full top word, which includes the phantom slot 255.
- A mask whose first target is absent, which separates lowest-priority selection from a plain presence filter.

Each mode is exercised once, including the INIT de-assert case. The command stream is compared item by item against an independent model. The latency from acceptance to `done` is also checked, so a skipped empty word or a stalled bit both show up.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    typedef enum logic [1:0] {
        DM_FIXED  = 2'd0,
        DM_LOWEST = 2'd1,
        DM_INIT   = 2'd2,
        DM_START  = 2'd3
    } dmode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } dstate_e;
endpackage

// File: rtl/irqd_word_sel.sv
module irqd_word_sel #(
    parameter int NUM_WORDS = 8,
    parameter int WORD_W    = 32,
    localparam int WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic [NUM_WORDS*WORD_W-1:0] mask_flat,
    input  logic [WIDX_W-1:0]           word_idx,
    output logic [WORD_W-1:0]           word_out
);
    logic [WORD_W-1:0] words [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_split
        assign words[g] = mask_flat[g*WORD_W +: WORD_W];
    end

    always_comb begin
        word_out = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_idx == WIDX_W'(w)) word_out = words[w];
        end
    end
endmodule

// File: rtl/irqd_lsb_pick.sv
module irqd_lsb_pick #(
    parameter int WORD_W  = 32,
    localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic [WORD_W-1:0] word_in,
    output logic              found,
    output logic [BIT_W-1:0]  bit_idx,
    output logic [WORD_W-1:0] rest
);
    always_comb begin
        found   = |word_in;
        bit_idx = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (word_in[i]) bit_idx = BIT_W'(i);
        end
        rest = word_in & (word_in - WORD_W'(1));
    end
endmodule

// File: rtl/irq_fanout_dispatch.sv
module irq_fanout_dispatch
    import irqd_pkg::*;
#(
    parameter int NUM_AGENTS = 255,
    parameter int WORD_W     = 32,
    parameter int VEC_W      = 8,
    localparam int NUM_WORDS = (NUM_AGENTS + WORD_W - 1) / WORD_W + ((NUM_AGENTS % WORD_W) == 0 ? 1 : 0),
    localparam int MASK_W    = NUM_WORDS * WORD_W,
    localparam int IDX_W     = $clog2(MASK_W),
    localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int BIT_W     = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [MASK_W-1:0]     req_mask,
    input  logic [1:0]            req_mode,
    input  logic [VEC_W-1:0]      req_vector,
    input  logic                  req_trig,
    input  logic                  req_level,
    input  logic [NUM_AGENTS-1:0] agent_present,
    output logic                  busy,
    output logic                  done,
    output logic                  cmd_set,
    output logic                  cmd_init,
    output logic                  cmd_start,
    output logic                  cmd_arb,
    output logic [IDX_W-1:0]      cmd_agent,
    output logic [VEC_W-1:0]      cmd_vector,
    output logic                  cmd_trig
);
    dstate_e            state_q, state_d;
    dmode_e             mode_q;
    logic [VEC_W-1:0]   vec_q;
    logic               trig_q;
    logic               arb_only_q;
    logic [WIDX_W-1:0]  widx_q;
    logic [MASK_W-1:0]  wmask_q;
    logic [MASK_W-1:0]  pres_q;
    logic [MASK_W-1:0]  pres_ext;

    logic [WORD_W-1:0]  cur_word;
    logic [WORD_W-1:0]  rest_word;
    logic               hit;
    logic [BIT_W-1:0]   hit_bit;
    logic [IDX_W-1:0]   hit_agent;
    logic               last_word;
    logic               accept;
    logic               issue;
    logic               advance;

    // Presence widened to the mask; slots past the agent count read as absent.
    for (genvar g = 0; g < MASK_W; g++) begin : g_pres
        if (g < NUM_AGENTS) begin : g_real
            assign pres_ext[g] = agent_present[g];
        end else begin : g_void
            assign pres_ext[g] = 1'b0;
        end
    end

    irqd_word_sel #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_word_sel (
        .mask_flat (wmask_q),
        .word_idx  (widx_q),
        .word_out  (cur_word)
    );

    irqd_lsb_pick #(.WORD_W(WORD_W)) u_lsb_pick (
        .word_in (cur_word),
        .found   (hit),
        .bit_idx (hit_bit),
        .rest    (rest_word)
    );

    assign hit_agent = IDX_W'({widx_q, hit_bit});
    assign last_word = (widx_q == WIDX_W'(NUM_WORDS - 1));
    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign issue     = (state_q == ST_SCAN) && hit;
    assign advance   = (state_q == ST_SCAN) && !last_word &&
                       (!hit || (mode_q != DM_LOWEST && rest_word == '0));
    assign busy      = (state_q != ST_IDLE);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_SCAN;
            ST_SCAN: begin
                if (hit && mode_q == DM_LOWEST)          state_d = ST_FINISH;
                else if (last_word && (!hit || rest_word == '0)) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            mode_q     <= DM_FIXED;
            vec_q      <= '0;
            trig_q     <= 1'b0;
            arb_only_q <= 1'b0;
            widx_q     <= '0;
            wmask_q    <= '0;
            pres_q     <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                mode_q     <= dmode_e'(req_mode);
                vec_q      <= req_vector;
                trig_q     <= req_trig;
                arb_only_q <= !req_level && req_trig;
                widx_q     <= '0;
                pres_q     <= pres_ext;
                wmask_q    <= (dmode_e'(req_mode) == DM_LOWEST) ? req_mask
                                                                 : (req_mask & pres_ext);
            end else begin
                if (issue) wmask_q[widx_q*WORD_W +: WORD_W] <= rest_word;
                if (advance) widx_q <= widx_q + WIDX_W'(1);
            end
        end
    end

    // Registered command and completion outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            cmd_set    <= 1'b0;
            cmd_init   <= 1'b0;
            cmd_start  <= 1'b0;
            cmd_arb    <= 1'b0;
            cmd_agent  <= '0;
            cmd_vector <= '0;
            cmd_trig   <= 1'b0;
        end else begin
            done      <= (state_q == ST_FINISH);
            cmd_set   <= 1'b0;
            cmd_init  <= 1'b0;
            cmd_start <= 1'b0;
            cmd_arb   <= 1'b0;
            if (issue && pres_q[hit_agent]) begin
                cmd_agent  <= hit_agent;
                cmd_vector <= vec_q;
                cmd_trig   <= trig_q;
                unique case (mode_q)
                    DM_FIXED, DM_LOWEST: cmd_set   <= 1'b1;
                    DM_INIT:   if (arb_only_q) cmd_arb <= 1'b1;
                               else            cmd_init <= 1'b1;
                    DM_START:  cmd_start <= 1'b1;
                    default:   cmd_set   <= 1'b0;
                endcase
            end
        end
    end

    logic any_stb;
    assign any_stb = cmd_set | cmd_init | cmd_start | cmd_arb;

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_set, cmd_init, cmd_start, cmd_arb})); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !any_stb); // R9
    AST_STB_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> pres_q[cmd_agent]); // R8
    AST_LOWEST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (any_stb && mode_q == DM_LOWEST) |=> !any_stb); // R4
    AST_INIT_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == DM_INIT) |-> !cmd_set); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !any_stb); // R10
endmodule

// File: tb/irq_fanout_dispatch_bench.sv
module irq_fanout_dispatch_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [255:0] req_mask = '0;
    logic [1:0]   req_mode = '0;
    logic [7:0]   req_vector = '0;
    logic         req_trig = 1'b0;
    logic         req_level = 1'b0;
    logic [254:0] agent_present = '1;
    logic         busy, done, cmd_set, cmd_init, cmd_start, cmd_arb, cmd_trig;
    logic [7:0]   cmd_agent, cmd_vector;

    irq_fanout_dispatch u_irq_fanout_dispatch (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mask(req_mask),
        .req_mode(req_mode), .req_vector(req_vector), .req_trig(req_trig),
        .req_level(req_level), .agent_present(agent_present), .busy(busy),
        .done(done), .cmd_set(cmd_set), .cmd_init(cmd_init), .cmd_start(cmd_start),
        .cmd_arb(cmd_arb), .cmd_agent(cmd_agent), .cmd_vector(cmd_vector),
        .cmd_trig(cmd_trig)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [255:0] mask;
        logic [1:0]   mode;
        logic [7:0]   vec;
        logic         trig;
        logic         level;
        logic [254:0] pres;
    } vec_t;

    localparam logic [254:0] ALL = '1;
    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        // R2 R3: sparse fixed request over several words
        '{(256'd1<<0)|(256'd1<<5)|(256'd1<<31)|(256'd1<<40)|(256'd1<<254), 2'd0, 8'h41, 1'b1, 1'b1, ALL},
        // R9: empty mask, full walk
        '{256'd0, 2'd0, 8'h11, 1'b0, 1'b1, ALL},
        // R4: lowest priority chooses agent 70
        '{(256'd1<<70)|(256'd1<<100)|(256'd1<<200), 2'd1, 8'h52, 1'b0, 1'b1, ALL},
        // R4: lowest priority, empty mask
        '{256'd0, 2'd1, 8'h53, 1'b0, 1'b1, ALL},
        // R4 R8: lowest priority, first target absent
        '{(256'd1<<33)|(256'd1<<34), 2'd1, 8'h54, 1'b1, 1'b1, ALL & ~(255'd1<<33)},
        // R5: INIT
        '{(256'd1<<3)|(256'd1<<4)|(256'd1<<64), 2'd2, 8'h00, 1'b0, 1'b1, ALL},
        // R6 R8: INIT de-assert, bit 255 has no slot
        '{(256'd1<<10)|(256'd1<<255), 2'd2, 8'h00, 1'b1, 1'b0, ALL},
        // R7 R8: startup, agent 128 absent
        '{(256'd1<<128)|(256'd1<<129), 2'd3, 8'h9A, 1'b0, 1'b1, ALL & ~(255'd1<<128)},
        // R3 R9: full top word
        '{{32'hFFFF_FFFF, 224'd0}, 2'd0, 8'h77, 1'b0, 1'b1, ALL}
    };

    int tests = 0, fails = 0;
    int lg_n = 0, done_cnt = 0;
    int lg_kind [512], lg_agent [512], lg_vec [512], lg_trig [512];
    int e_n, e_k;
    int e_kind [512], e_agent [512];

    // kind: 1 set, 2 init, 3 startup, 4 arbitration reload
    always @(negedge clk) begin
        if (cmd_set | cmd_init | cmd_start | cmd_arb) begin
            lg_kind[lg_n]  = cmd_set ? 1 : cmd_init ? 2 : cmd_start ? 3 : 4;
            lg_agent[lg_n] = int'(cmd_agent);
            lg_vec[lg_n]   = int'(cmd_vector);
            lg_trig[lg_n]  = int'(cmd_trig);
            lg_n++;
        end
        if (done) done_cnt++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model(input vec_t v);
        logic [255:0] f;
        int nz;
        e_n = 0;
        if (v.mode == 2'd1) begin
            e_k = 8;
            for (int i = 0; i < 256; i++) begin
                if (v.mask[i]) begin
                    e_k = i / 32 + 1;
                    if (i < 255 && v.pres[i]) begin
                        e_kind[0] = 1; e_agent[0] = i; e_n = 1;
                    end
                    break;
                end
            end
        end else begin
            f = v.mask & {1'b0, v.pres};
            nz = 0;
            for (int w = 0; w < 8; w++) if (f[w*32 +: 32] != 0) nz++;
            for (int i = 0; i < 256; i++) begin
                if (f[i]) begin
                    e_agent[e_n] = i;
                    e_kind[e_n]  = (v.mode == 2'd0) ? 1 : (v.mode == 2'd3) ? 3 :
                                   (!v.level && v.trig) ? 4 : 2;
                    e_n++;
                end
            end
            e_k = 8 - nz + e_n;
        end
    endtask

    task automatic run(input vec_t v, input bit interfere);
        int c;
        model(v);
        @(negedge clk);
        lg_n = 0; done_cnt = 0;
        req_mask = v.mask; req_mode = v.mode; req_vector = v.vec;
        req_trig = v.trig; req_level = v.level; agent_present = v.pres;
        req_valid = 1'b1;
        c = 0;
        while (1) begin
            @(negedge clk);
            c++;
            if (interfere && c < 4) begin
                req_valid = 1'b1; req_mode = 2'd2; req_mask = '1;   // R10 noise while busy
            end else begin
                req_valid = 1'b0;
            end
            if (done || c > 400) break;
        end
        req_valid = 1'b0;
        check(c == e_k + 2, "R9 latency", c, e_k + 2);
        @(negedge clk);
        check(!done, "R9 done single pulse", int'(done), 0);
        check(lg_n == e_n, "R3/R4/R8 command count", lg_n, e_n);
        for (int i = 0; i < e_n && i < lg_n; i++) begin
            check(lg_kind[i] == e_kind[i], "R5/R6/R7 command kind", lg_kind[i], e_kind[i]);
            check(lg_agent[i] == e_agent[i], "R2 agent index", lg_agent[i], e_agent[i]);
            if (e_kind[i] == 1 || e_kind[i] == 3)
                check(lg_vec[i] == int'(v.vec), "R3/R7 vector", lg_vec[i], int'(v.vec));
            if (e_kind[i] == 1)
                check(lg_trig[i] == int'(v.trig), "R3 trigger", lg_trig[i], int'(v.trig));
        end
        if (interfere) begin
            repeat (30) @(negedge clk);
            check(done_cnt == 1, "R10 no second done", done_cnt, 1);
            check(!busy, "R10 idle after walk", int'(busy), 0);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        fails++; tests++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done, "R1 reset idle", int'(busy | done), 0);
        check(!(cmd_set | cmd_init | cmd_start | cmd_arb), "R1 reset strobes",
              int'(cmd_set | cmd_init | cmd_start | cmd_arb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1 idle after release", int'(busy | done), 0);

        for (int t = 0; t < NV; t++) run(TBL[t], 1'b0);

        // R10: request held high during a walk of agents 0..7
        run('{256'h0FF, 2'd0, 8'h23, 1'b1, 1'b1, ALL}, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule